// File: doc/BRIEF.md
# Dual-Source Serial Bit-Rate Tick Generator

This block produces the 16x oversampling tick enables for two serial ports of a microcontroller. Each tick is a one-cycle strobe. Port 0 takes its rate from one of two sources, chosen by `src_sel`:

- **Timer source.** An 8-bit auto-reload timer, prescaled by 12, reloads from `tmr_reload`.
- **Internal source.** A 10-bit up-counting reload counter, prescaled by 2.

The resulting 16x tick rates are:

- Port 0, timer source: 2^SMOD·fclk/(24·(256−TH)).
- Port 0, internal source: 2^SMOD·fclk/(4·(1024−REL0)).
- Port 1: fclk/(2·(1024−REL1)). Port 1 always runs from its own 10-bit reload counter and ignores both `smod` and `src_sel`.

Each 10-bit reload value is built from a low byte and the two low bits of a high byte. A reload counter samples its reload value only when it wraps, so a register write never disturbs a period that is already in progress.

The port-0 output passes through a two-state halving machine. The states are HALF_EVEN and HALF_ODD, and the transitions are as follows:

- **EVEN_PASS.** In HALF_EVEN, a source pulse with `smod` = 1 emits a tick and stays in HALF_EVEN.
- **EVEN_SWALLOW.** In HALF_EVEN, a source pulse with `smod` = 0 emits no tick and moves to HALF_ODD.
- **ODD_EMIT.** In HALF_ODD, a source pulse emits a tick and returns to HALF_EVEN.
- **RESYNC.** From either state, a change of `src_sel` forces HALF_EVEN with no tick.
- **HOLD.** Otherwise the state is unchanged.

Top module: `baud_gen_top`

## Requirements
- R1: While reset is low both ticks are 0. All counters, prescalers and the halving machine start from zero and HALF_EVEN. The first port-1 tick appears on the 2047th rising edge after reset is released.
- R2: In steady state, port-1 ticks are 2·(1024−REL1) clock cycles apart.
- R3: `smod` and `src_sel` have no effect on the port-1 tick spacing.
- R4: With `src_sel`=1 and `smod`=1, port-0 ticks are 2·(1024−REL0) cycles apart.
- R5: With `smod`=0, the port-0 spacing is twice the `smod`=1 spacing, for either source.
- R6: With `src_sel`=0 and `smod`=1, port-0 ticks are 12·(256−TH) cycles apart, where TH is `tmr_reload`.
- R7: `src_sel`=0 selects the timer source and `src_sel`=1 selects the internal source for port 0.
- R8: A 10-bit reload value is {hi[1:0], lo[7:0]}. Bits hi[7:2] have no effect on the spacing.
- R9: A reload write made in the middle of a period leaves that period at its old length. The new value applies from the next wrap.
- R10: Each tick is high for exactly one clock cycle and is never high on two consecutive cycles.
- R11: A reload value of 1023 gives the shortest spacing, which is 2 cycles for port 1 and for internal-source port 0 with `smod`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | Port-0 source: 0 timer, 1 internal counter |
| smod | input | 1 | Port-0 rate doubling bit |
| tmr_reload | input | 8 | Timer auto-reload byte |
| rel0_lo | input | 8 | Port-0 reload, low byte |
| rel0_hi | input | 8 | Port-0 reload, high byte (bits 1:0 used) |
| rel1_lo | input | 8 | Port-1 reload, low byte |
| rel1_hi | input | 8 | Port-1 reload, high byte (bits 1:0 used) |
| tick0 | output | 1 | Port-0 16x oversample tick enable |
| tick1 | output | 1 | Port-1 16x oversample tick enable |

## Verification
The bench measures tick spacings in clock cycles and compares them with values computed from the rate formulas.

- **Mid-period reload write.** A design that loaded the reload value at any time other than the wrap would shorten or stretch the period in which the write lands.
- **Reload of 1023.** A counter that failed to reload on every enable would return 1024 cycles or more instead of 2.
- **High-byte junk bits.** Setting hi[7:2] would alter the spacing if the reload were assembled with the wrong bits.
- **Halving stage.** Switching `smod` on each source exposes a halving stage that is inverted or bypassed.
- **Port-1 isolation.** Toggling `smod` and `src_sel` with port 1 running would reveal any leak of port-0 controls into port 1.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic {
        HALF_EVEN = 1'b0,
        HALF_ODD  = 1'b1
    } half_state_t;

    localparam int TIMER_W   = 8;
    localparam int RELOAD_W  = 10;
    localparam int TIMER_PRE = 12;
    localparam int INT_PRE   = 2;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    always_comb pulse = (cnt == LAST);
endmodule

// File: rtl/baud_reload_counter.sv
module baud_reload_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] reload,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] count;

    always_comb wrap = en && (count == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (wrap)   count <= reload;
        else if (en)     count <= count + 1'b1;
    end

    // R2: the count holds between enables
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

    // R9: the reload value is sampled only at the wrap
    p_load_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count == $past(reload));
endmodule

// File: rtl/baud_half_fsm.sv
module baud_half_fsm
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_pulse,
    input  logic smod,
    input  logic resync,
    output logic tick
);
    half_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= HALF_EVEN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        tick     = 1'b0;
        if (resync) begin
            state_nx = HALF_EVEN;
        end else if (src_pulse) begin
            unique case (state)
                HALF_EVEN: begin
                    if (smod) tick = 1'b1;
                    else      state_nx = HALF_ODD;
                end
                HALF_ODD: begin
                    tick     = 1'b1;
                    state_nx = HALF_EVEN;
                end
                default: state_nx = HALF_EVEN;
            endcase
        end
    end

    // R4: doubling mode passes every source pulse from HALF_EVEN
    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HALF_EVEN && src_pulse && smod && !resync) |=> state == HALF_EVEN);

    // R5: without doubling, a tick can only leave HALF_ODD
    p_halve_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !smod) |-> state == HALF_ODD);
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_sel,
    input  logic       smod,
    input  logic [7:0] tmr_reload,
    input  logic [7:0] rel0_lo,
    input  logic [7:0] rel0_hi,
    input  logic [7:0] rel1_lo,
    input  logic [7:0] rel1_hi,
    output logic       tick0,
    output logic       tick1
);
    localparam int NPORT = 2;
    localparam int HI_W  = RELOAD_W - 8;

    logic tmr_en, int_en, tmr_wrap;
    logic [RELOAD_W-1:0] rel_val  [NPORT];
    logic [NPORT-1:0]    int_wrap;
    logic sel_q;

    always_comb begin
        rel_val[0] = {rel0_hi[HI_W-1:0], rel0_lo};
        rel_val[1] = {rel1_hi[HI_W-1:0], rel1_lo};
    end

    baud_prescaler #(.DIV(TIMER_PRE)) u_tmr_pre (
        .clk(clk), .rst_n(rst_n), .pulse(tmr_en));

    baud_prescaler #(.DIV(INT_PRE)) u_int_pre (
        .clk(clk), .rst_n(rst_n), .pulse(int_en));

    baud_reload_counter #(.W(TIMER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(tmr_en),
        .reload(tmr_reload), .wrap(tmr_wrap));

    for (genvar p = 0; p < NPORT; p++) begin : g_int
        baud_reload_counter #(.W(RELOAD_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .en(int_en),
            .reload(rel_val[p]), .wrap(int_wrap[p]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= src_sel;
    end

    logic p0_src, p0_resync;
    always_comb begin
        p0_src    = src_sel ? int_wrap[0] : tmr_wrap;
        p0_resync = (src_sel != sel_q);
    end

    baud_half_fsm u_half (
        .clk(clk), .rst_n(rst_n), .src_pulse(p0_src),
        .smod(smod), .resync(p0_resync), .tick(tick0));

    always_comb tick1 = int_wrap[1];

    // R10: port-1 tick lasts one cycle
    p_tick1_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick1 |=> !tick1);

    // R10: port-0 tick lasts one cycle
    p_tick0_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick0 |=> !tick0);

    // R7: a port-0 tick coincides with a wrap of the selected source
    p_tick0_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick0 |-> (src_sel ? int_wrap[0] : tmr_wrap));
endmodule

// File: tb/sim_baud_gen_top.sv
module sim_baud_gen_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_sel = 1'b1, smod = 1'b1;
    logic [7:0] tmr_reload = 8'd0;
    logic [7:0] rel0_lo = 8'd0, rel0_hi = 8'd0, rel1_lo = 8'd0, rel1_hi = 8'd0;
    logic tick0, tick1;

    int n_cmp = 0;
    int n_bad = 0;
    int dbl0 = 0, dbl1 = 0;
    logic prev0 = 1'b0, prev1 = 1'b0;

    always #4 clk = ~clk;

    baud_gen_top u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .smod(smod),
        .tmr_reload(tmr_reload), .rel0_lo(rel0_lo), .rel0_hi(rel0_hi),
        .rel1_lo(rel1_lo), .rel1_hi(rel1_hi), .tick0(tick0), .tick1(tick1));

    always @(negedge clk) begin
        if (rst_n) begin
            if (tick0 && prev0) dbl0++;
            if (tick1 && prev1) dbl1++;
        end
        prev0 = tick0;
        prev1 = tick1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(input bit which);
        int t = 0;
        @(negedge clk);
        while (!(which ? tick1 : tick0) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 20000) check("timeout", t, 0);
    endtask

    task automatic measure(input bit which, output int n);
        wait_tick(which);
        n = 1;
        @(negedge clk);
        while (!(which ? tick1 : tick0) && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic spacing(input bit which, input string req, input int exp);
        int n;
        wait_tick(which);
        wait_tick(which);
        measure(which, n);
        check(req, n, exp);
    endtask

    task automatic t_reset_r1();
        int n = 0;
        repeat (3) @(negedge clk);
        check("R1 tick0 in reset", int'(tick0), 0);
        check("R1 tick1 in reset", int'(tick1), 0);
        rst_n = 1'b1;
        @(negedge clk);
        n = 1;
        while (!tick1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check("R1 first port-1 tick", n, 2047);
    endtask

    task automatic t_port1_r2_r8();
        rel1_hi = 8'h03; rel1_lo = 8'hE0;            // 992
        spacing(1'b1, "R2 port-1 spacing 992", 64);
        rel1_hi = 8'hFD; rel1_lo = 8'hF0;            // {01,F0} = 496
        spacing(1'b1, "R8 high-byte junk bits ignored", 1056);
    endtask

    task automatic t_port1_iso_r3();
        rel1_hi = 8'h03; rel1_lo = 8'hC0;            // 960
        smod = 1'b0; src_sel = 1'b0;
        spacing(1'b1, "R3 port-1 with smod0 sel0", 128);
        smod = 1'b1; src_sel = 1'b1;
        spacing(1'b1, "R3 port-1 with smod1 sel1", 128);
    endtask

    task automatic t_internal_r4_r5_r7();
        src_sel = 1'b1; smod = 1'b1;
        rel0_hi = 8'h03; rel0_lo = 8'hE8;            // 1000
        spacing(1'b0, "R4 R7 internal smod1", 48);
        smod = 1'b0;
        spacing(1'b0, "R5 internal smod0", 96);
    endtask

    task automatic t_timer_r6_r5_r7();
        src_sel = 1'b0; smod = 1'b1;
        tmr_reload = 8'd250;
        spacing(1'b0, "R6 R7 timer smod1", 72);
        smod = 1'b0;
        spacing(1'b0, "R5 timer smod0", 144);
    endtask

    task automatic t_midwrite_r9();
        int n = 0;
        rel1_hi = 8'h03; rel1_lo = 8'hE0;            // 992 -> 64 cycles
        wait_tick(1'b1);
        wait_tick(1'b1);
        wait_tick(1'b1);
        repeat (10) begin
            @(negedge clk);
            n++;
        end
        rel1_lo = 8'hC0;                             // 960 -> 128 cycles
        @(negedge clk);
        n++;
        while (!tick1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check("R9 in-progress period keeps old length", n, 64);
        measure(1'b1, n);
        check("R9 new reload after wrap", n, 128);
    endtask

    task automatic t_min_r11();
        rel1_hi = 8'h03; rel1_lo = 8'hFF;
        spacing(1'b1, "R11 port-1 reload 1023", 2);
        src_sel = 1'b1; smod = 1'b1;
        rel0_hi = 8'h03; rel0_lo = 8'hFF;
        spacing(1'b0, "R11 port-0 reload 1023", 2);
    endtask

    initial begin
        t_reset_r1();
        t_port1_r2_r8();
        t_port1_iso_r3();
        t_internal_r4_r5_r7();
        t_timer_r6_r5_r7();
        t_midwrite_r9();
        t_min_r11();
        check("R10 port-0 double-cycle ticks", dbl0, 0);
        check("R10 port-1 double-cycle ticks", dbl1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule